// File: doc/BRIEF.md
# Serial Receiver with End-of-Message Detection

This block turns an asynchronous serial line into bytes. Each frame has one start bit, eight data bits sent least significant bit first, and one stop bit. The receiver oversamples the line sixteen times per bit and takes each bit at its centre. Bytes come out on a parallel bus together with a one-cycle valid strobe.

Alongside the byte path, the block watches how long the line stays quiet after a byte. This lets software find the end of a message whose length is not known in advance. Two quiet detectors run in parallel. Both start counting only after a byte has been received.
- The line-idle detector has a fixed window of one frame time, which is ten bit times.
- The timeout detector has a window of a programmable number of bit times.

Each detector sets a sticky flag. Software clears a flag by pulsing its clear input. Each flag has its own interrupt enable, and one interrupt output combines the enabled flags.

Top module: `uart_rx_eom`

## Requirements
- R1: While reset is applied and right after it, `rx_valid_o`, `rx_data_o`, both flags and `irq_o` are all zero.
- R2: A frame on `rx_i` is received as follows:
  - The line idles high and a frame begins with a low start bit.
  - Eight data bits follow, least significant bit first, then a high stop bit.
  - The received frame produces exactly one single-cycle `rx_valid_o` pulse, with the byte on `rx_data_o`.
- R3: A start bit that is high again at its midpoint (eight oversampling ticks after it was seen) is dropped. It produces no byte and does not arm either quiet detector.
- R4: A frame whose stop bit is sampled low is discarded. It produces no `rx_valid_o` pulse and does not arm the quiet detectors.
- R5: The line-idle flag sets once the line has stayed high for ten bit times after the stop-bit sample of a received byte. It is not set nine bit times after the end of the stop bit, and it is set eleven bit times after the end of the stop bit.
- R6: Each detector fires at most once per received byte. After its flag is cleared, it stays clear on a quiet line until a new byte arrives.
- R7: Neither flag sets after reset until at least one byte has been received.
- R8: The timeout flag sets after `rto_len_i` bit times of quiet following a received byte. A value of zero disables the timeout detector.
- R9: A low level on the line (a new start bit) during a quiet count restarts the count from zero. Bytes separated by gaps shorter than the window therefore raise no event.
- R10: Each flag stays set until its own clear strobe is pulsed. Clearing one flag leaves the other unchanged.
- R11: `irq_o` is high exactly when (idle flag AND idle enable) OR (timeout flag AND timeout enable). The enables do not change the flags.
- R12: One bit time lasts 16 × (`baud_div_i` + 1) clock cycles. Both reception and the quiet windows scale with this bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, high when idle |
| baud_div_i | input | DIV_W | Oversampling tick period minus one, in clocks |
| rto_len_i | input | LEN_W | Timeout window in bit times; 0 disables it |
| idle_en_i | input | 1 | Interrupt enable for the line-idle flag |
| rto_en_i | input | 1 | Interrupt enable for the timeout flag |
| idle_clr_i | input | 1 | Clear strobe for the line-idle flag |
| rto_clr_i | input | 1 | Clear strobe for the timeout flag |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe marking a new byte |
| idle_flag_o | output | 1 | Sticky line-idle event flag |
| rto_flag_o | output | 1 | Sticky timeout event flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench probes several corner cases, each of which exposes a specific class of bug:
- A short low glitch right after reset. A receiver that skips the midpoint check would emit a phantom byte, and one that arms on any activity would raise an idle flag.
- A frame with a low stop bit. A design that ignores the stop bit would deliver a corrupt byte.
- Idle and timeout timing, checked on both sides of each window at two baud divisors. An off-by-one bit count or an unscaled window moves the flag across those sample points.
- Bursts with gaps just under the idle window, long quiet stretches after a clear, and a zero timeout length. These catch a count that fails to restart, a detector that re-fires without a new byte, and a zero length that wraps into an early event.

// File: rtl/uart_eom_pkg.sv
// Shared constants and types for the end-of-message serial receiver.
package uart_eom_pkg;
    localparam int OVS        = 16;            // oversampling ticks per bit
    localparam int PH_W       = $clog2(OVS);   // width of the in-bit phase counter
    localparam int MID_PH     = OVS / 2 - 1;   // phase value at the start-bit midpoint
    localparam int LAST_PH    = OVS - 1;       // phase value at a full bit period
    localparam int FRAME_BITS = 10;            // start + 8 data + stop

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/uart_eom_tick.sv
// Oversampling tick generator.
// Emits a one-cycle pulse every div_i+1 clocks. Assumes div_i changes
// only while the line is idle; a smaller value takes effect at once.
module uart_eom_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    // Count up to the divisor and pulse on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (cnt >= div_i) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_eom_deser.sv
// Frame deserialiser for one start, DATA_W data (LSB first) and one stop bit.
// Assumes rx_i is already synchronised and that tick_i runs at 16x the bit
// rate. Start bits are checked at their midpoint; a low stop bit drops the byte.
module uart_eom_deser
    import uart_eom_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              busy_o
);
    localparam int BIT_W = $clog2(DATA_W + 1);

    rx_state_e         st;
    logic [PH_W-1:0]   ph;
    logic [BIT_W-1:0]  idx;
    logic [DATA_W-1:0] sh;

    // Frame state machine: find start, shift data at mid-bit, check stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= RX_IDLE;
            ph      <= '0;
            idx     <= '0;
            sh      <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (tick_i) begin
                case (st)
                    RX_IDLE: begin
                        if (!rx_i) begin
                            st <= RX_START;
                            ph <= '0;
                        end
                    end
                    RX_START: begin
                        if (ph == PH_W'(MID_PH)) begin
                            st  <= rx_i ? RX_IDLE : RX_DATA;
                            ph  <= '0;
                            idx <= '0;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (ph == PH_W'(LAST_PH)) begin
                            ph <= '0;
                            sh <= {rx_i, sh[DATA_W-1:1]};
                            if (idx == BIT_W'(DATA_W - 1)) st <= RX_STOP;
                            else idx <= idx + 1'b1;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    default: begin
                        if (ph == PH_W'(LAST_PH)) begin
                            st <= RX_IDLE;
                            ph <= '0;
                            if (rx_i) begin
                                data_o  <= sh;
                                valid_o <= 1'b1;
                            end
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // Receiver is busy whenever a frame is in progress.
    always_comb busy_o = (st != RX_IDLE);

    p_valid_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(rx_i));
    p_start_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_START && tick_i && ph == PH_W'(MID_PH) && rx_i) |=> (st == RX_IDLE && !valid_o));
endmodule

// File: rtl/uart_eom_quiet.sv
// Quiet-line detector.
// Armed by a received byte, it counts oversampling ticks while the line is
// high and no frame is active. It fires once after len_i bit times, then
// disarms. A low line restarts the count. A length of zero never fires.
module uart_eom_quiet
    import uart_eom_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             byte_i,
    input  logic             busy_i,
    input  logic             line_hi_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             fire_o
);
    localparam int CNT_W = LEN_W + PH_W;

    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;

    // Window length in ticks: bit times times the oversampling factor.
    always_comb target = {len_i, {PH_W{1'b0}}};

    // Arm on a byte, count quiet ticks, fire once at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            cnt    <= '0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (byte_i) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (busy_i || !line_hi_i) begin
                cnt <= '0;
            end else if (armed && tick_i && len_i != '0) begin
                if (cnt == target - 1'b1) begin
                    fire_o <= 1'b1;
                    armed  <= 1'b0;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    p_no_fire_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !fire_o);
    p_zero_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (len_i == '0) |=> !fire_o);
endmodule

// File: rtl/uart_eom_flag.sv
// Sticky event flag with a clear strobe. A set in the same cycle as a
// clear wins, so an event is never lost.
module uart_eom_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag until it is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/uart_rx_eom.sv
// Serial receiver with line-idle and programmable timeout events.
// Synchronises rx_i, deserialises 8N1 frames, and runs two quiet
// detectors (a fixed one-frame window and a programmable window). Each
// detector feeds a sticky flag, and the enabled flags combine into irq_o.
module uart_rx_eom
    import uart_eom_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int LEN_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic [DIV_W-1:0]  baud_div_i,
    input  logic [LEN_W-1:0]  rto_len_i,
    input  logic              idle_en_i,
    input  logic              rto_en_i,
    input  logic              idle_clr_i,
    input  logic              rto_clr_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              idle_flag_o,
    output logic              rto_flag_o,
    output logic              irq_o
);
    localparam int N_EV = 2;   // event 0: line idle, event 1: timeout

    logic             rx_meta, rx_s, tick, busy;
    logic [N_EV-1:0]  ev_fire, ev_flag, ev_clr;
    logic [LEN_W-1:0] ev_len [N_EV];

    // Two-flop synchroniser, reset to the idle (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= rx_i;
            rx_s    <= rx_meta;
        end
    end

    uart_eom_tick #(.DIV_W(DIV_W)) i_tick (
        .clk(clk), .rst_n(rst_n), .div_i(baud_div_i), .tick_o(tick)
    );

    uart_eom_deser #(.DATA_W(DATA_W)) i_deser (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_s),
        .data_o(rx_data_o), .valid_o(rx_valid_o), .busy_o(busy)
    );

    // Window lengths and clear strobes for each event.
    always_comb begin
        ev_len[0] = LEN_W'(FRAME_BITS);
        ev_len[1] = rto_len_i;
        ev_clr    = {rto_clr_i, idle_clr_i};
    end

    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        uart_eom_quiet #(.LEN_W(LEN_W)) i_quiet (
            .clk(clk), .rst_n(rst_n), .tick_i(tick), .byte_i(rx_valid_o),
            .busy_i(busy), .line_hi_i(rx_s), .len_i(ev_len[g]),
            .fire_o(ev_fire[g])
        );
        uart_eom_flag i_flag (
            .clk(clk), .rst_n(rst_n), .set_i(ev_fire[g]),
            .clr_i(ev_clr[g]), .flag_o(ev_flag[g])
        );
    end

    // Flag outputs and the combined, enabled interrupt.
    always_comb begin
        idle_flag_o = ev_flag[0];
        rto_flag_o  = ev_flag[1];
        irq_o       = (ev_flag[0] & idle_en_i) | (ev_flag[1] & rto_en_i);
    end

    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (idle_flag_o || rto_flag_o));
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!idle_flag_o && !rto_flag_o && !rx_valid_o));
endmodule

// File: tb/test_uart_rx_eom.sv
// Self-checking bench: random bytes plus directed end-of-message cases.
module test_uart_rx_eom;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic [15:0] div = 16'd3;
    logic [7:0]  rto_len = 8'd20;
    logic        idle_en = 1'b0, rto_en = 1'b0, idle_clr = 1'b0, rto_clr = 1'b0;
    logic [7:0]  data;
    logic        valid, idle_flag, rto_flag, irq;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] got_q[$];
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    uart_rx_eom i_uart_rx_eom (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_div_i(div),
        .rto_len_i(rto_len), .idle_en_i(idle_en), .rto_en_i(rto_en),
        .idle_clr_i(idle_clr), .rto_clr_i(rto_clr), .rx_data_o(data),
        .rx_valid_o(valid), .idle_flag_o(idle_flag), .rto_flag_o(rto_flag),
        .irq_o(irq)
    );

    // Collect received bytes away from the active edge.
    always @(negedge clk) if (rst_n && valid) got_q.push_back(data);

    function automatic int bit_clks(input logic [15:0] d);
        return 16 * (int'(d) + 1);
    endfunction

    function automatic logic exp_irq(input logic fi, fr, ei, er);
        return (fi & ei) | (fr & er);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * bit_clks(div)) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        rx = 1'b0;
        wait_bits(1);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            wait_bits(1);
        end
        rx = good_stop;
        wait_bits(1);
        rx = 1'b1;
    endtask

    task automatic clear_flags();
        idle_clr = 1'b1;
        rto_clr  = 1'b1;
        @(negedge clk);
        idle_clr = 1'b0;
        rto_clr  = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n_before;
        logic [7:0] b;
        void'($urandom(32'h5eed_1234));

        repeat (6) @(negedge clk);
        // R1: reset state.
        chk("R1 valid", valid, 0);
        chk("R1 data", data, 0);
        chk("R1 flags", {idle_flag, rto_flag}, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3 / R7: glitch shorter than half a bit.
        rx = 1'b0;
        repeat (bit_clks(div) / 4) @(negedge clk);
        rx = 1'b1;
        wait_bits(30);
        chk("R3 no byte from glitch", got_q.size(), 0);
        chk("R7 idle before any byte", idle_flag, 0);
        chk("R7 timeout before any byte", rto_flag, 0);

        // R2: random bytes with short gaps.
        for (int k = 0; k < 24; k++) begin
            b = 8'($urandom());
            exp_q.push_back(b);
            send_byte(b, 1'b1);
            wait_bits(int'($urandom_range(0, 4)));
        end
        wait_bits(25);
        chk("R2 byte count", got_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
            chk("R2 byte value", got_q[k], exp_q[k]);
        clear_flags();
        chk("R10 clear both", {idle_flag, rto_flag}, 0);

        // R5 / R8: window timing at rto_len = 20.
        send_byte(8'hA5, 1'b1);
        wait_bits(9);
        chk("R5 idle not yet at 9 bits", idle_flag, 0);
        wait_bits(2);
        chk("R5 idle at 11 bits", idle_flag, 1);
        chk("R8 timeout not yet at 11 bits", rto_flag, 0);
        wait_bits(8);
        chk("R8 timeout not yet at 19 bits", rto_flag, 0);
        wait_bits(2);
        chk("R8 timeout at 21 bits", rto_flag, 1);
        chk("R10 idle still set", idle_flag, 1);

        // R11: enables gate the interrupt only.
        idle_en = 1'b1;
        @(negedge clk);
        chk("R11 irq idle", irq, exp_irq(idle_flag, rto_flag, idle_en, rto_en));
        idle_clr = 1'b1;
        @(negedge clk);
        idle_clr = 1'b0;
        @(negedge clk);
        chk("R10 idle cleared", idle_flag, 0);
        chk("R10 timeout kept", rto_flag, 1);
        chk("R11 irq masked", irq, 0);
        rto_en = 1'b1;
        @(negedge clk);
        chk("R11 irq timeout", irq, 1);
        idle_en = 1'b0;
        rto_en  = 1'b0;
        @(negedge clk);
        chk("R11 enables leave flag", rto_flag, 1);
        clear_flags();
        chk("R11 irq after clear", irq, 0);

        // R6: no re-fire without a new byte.
        wait_bits(30);
        chk("R6 idle stays clear", idle_flag, 0);
        chk("R6 timeout stays clear", rto_flag, 0);

        // R9: gaps just under the idle window.
        for (int k = 0; k < 4; k++) begin
            b = 8'(8'h30 + k);
            exp_q.push_back(b);
            send_byte(b, 1'b1);
            wait_bits(8);
            chk("R9 no idle within gap", idle_flag, 0);
        end
        wait_bits(3);
        chk("R9 idle after burst", idle_flag, 1);
        clear_flags();

        // R8: zero length disables the timeout.
        rto_len = 8'd0;
        exp_q.push_back(8'h7E);
        send_byte(8'h7E, 1'b1);
        wait_bits(40);
        chk("R8 zero length no timeout", rto_flag, 0);
        chk("R8 idle still works", idle_flag, 1);
        clear_flags();
        rto_len = 8'd20;

        // R4: low stop bit drops the byte and arms nothing.
        n_before = got_q.size();
        send_byte(8'h5A, 1'b0);
        wait_bits(30);
        chk("R4 no byte on framing error", got_q.size(), n_before);
        chk("R4 no idle on framing error", idle_flag, 0);

        // R12: faster tick, same bit-time windows.
        div = 16'd1;
        repeat (4) @(negedge clk);
        send_byte(8'hC3, 1'b1);
        wait_bits(9);
        chk("R12 byte at new rate", got_q.size() > 0 ? got_q[got_q.size()-1] : 0, 8'hC3);
        chk("R12 idle not yet at 9 bits", idle_flag, 0);
        wait_bits(2);
        chk("R12 idle at 11 bits", idle_flag, 1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule